// File: doc/BRIEF.md
# AHB Master Retry Backoff Controller

This block is the master side of a single-transfer AHB port that does not give up on a transfer when the slave answers RETRY (or SPLIT, which it treats the same way). A local user hands it one command at a time: an address, a direction and, for writes, a data word. The block requests the bus, runs the address and data phases, and watches the response.

On OKAY it reports completion and returns the read data. On ERROR it reports failure at once. On RETRY it keeps the captured address, direction and write data, releases the bus request, and waits out a backoff delay before it requests the bus again. The delay starts from a configured base and doubles after each retry, never going past a configured ceiling.

A retry counter bounds the number of reissues. Once the configured limit of retries has been used, the next RETRY ends the command with a failure pulse. While a delay is running, the block neither asserts the bus request nor drives a transfer, so other masters can win arbitration.

Top module: `ahbm_retry_backoff`

## Requirements
- R1: After reset, and whenever no command is in progress, `hbusreq` is 0, `htrans` is IDLE (2'b00), and `cmd_done` and `cmd_fail` are 0.
- R2: A `cmd_req` seen while idle captures `cmd_addr`, `cmd_write` and `cmd_wdata` and raises `hbusreq`. After a cycle with `hgrant` and `hready` both 1, the next cycle drives `htrans` NONSEQ (2'b10) with the captured address and direction. These are held until `hready` is 1. The captured write data is driven on `hwdata` during the data phase.
- R3: A data phase ending with `hready`=1 and `hresp` OKAY (2'b00) gives a one-cycle `cmd_done` pulse in the next cycle. For a read, `cmd_rdata` in that cycle holds the `hrdata` value of the final data-phase cycle.
- R4: A RETRY (2'b10) or SPLIT (2'b11) response leads to a reissue of exactly the same transfer: same address, same direction, same write data.
- R5: The cycle after the first response cycle of a RETRY (`hready`=0) drives `htrans` IDLE, so no further transfer is pipelined behind the retried one.
- R6: After the final RETRY cycle, `hbusreq` stays 0 and `htrans` stays IDLE for exactly D+1 cycles, where D is the current backoff delay. After that, `hbusreq` rises again.
- R7: Within one command, the first backoff delay is min(base, max). Each following delay is min(2 × previous, max).
- R8: With a retry limit L, at most L reissues follow the first attempt. The (L+1)-th RETRY ends the command with a one-cycle `cmd_fail` pulse in the next cycle, and no further address phase follows. L=0 fails on the first RETRY.
- R9: An ERROR (2'b01) response gives a one-cycle `cmd_fail` pulse in the next cycle, with no retry. `cmd_done` and `cmd_fail` are never 1 together.
- R10: `cmd_req` is ignored while a command is in progress. It neither changes the transfer being retried nor starts a second command.
- R11: Every new command starts with the retry count at zero and the delay back at min(base, max), whatever the previous command did.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base_dly | input | DLY_W | Backoff delay before the first reissue |
| cfg_max_dly | input | DLY_W | Ceiling on the backoff delay |
| cfg_retry_limit | input | CNT_W | Maximum number of reissues per command |
| cmd_req | input | 1 | Start a command (taken only when idle) |
| cmd_addr | input | ADDR_W | Command address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | DATA_W | Write data |
| cmd_done | output | 1 | One-cycle pulse: command completed with OKAY |
| cmd_fail | output | 1 | One-cycle pulse: ERROR response or retry limit exhausted |
| cmd_rdata | output | DATA_W | Read data of the last successful read |
| hbusreq | output | 1 | Bus request to the arbiter |
| hgrant | input | 1 | Bus grant from the arbiter |
| haddr | output | ADDR_W | Transfer address |
| htrans | output | 2 | Transfer type (IDLE 2'b00, NONSEQ 2'b10) |
| hwrite | output | 1 | Transfer direction |
| hsize | output | 3 | Transfer size, fixed to the data width |
| hwdata | output | DATA_W | Write data |
| hrdata | input | DATA_W | Read data from the slave |
| hready | input | 1 | Transfer ready |
| hresp | input | 2 | Slave response |

## Verification
The bench builds the block with DLY_W=6 and CNT_W=3. With a ceiling no higher than 63 and only a few doublings, runs reach the cap, and retry limits cover the whole range from 0 to 7. Random configurations also include bases above the ceiling and a zero base. Each command is scripted with between zero retries and one retry past the limit, so both the success path and exhaustion show up at every limit value. A slave model adds wait states and random grant delays, and sometimes sends a stray request during a backoff.

// File: rtl/ahbm_rb_pkg.sv
package ahbm_rb_pkg;

  localparam logic [1:0] HT_IDLE   = 2'b00;
  localparam logic [1:0] HT_NONSEQ = 2'b10;

  localparam logic [1:0] HR_OKAY  = 2'b00;
  localparam logic [1:0] HR_ERROR = 2'b01;
  localparam logic [1:0] HR_RETRY = 2'b10;
  localparam logic [1:0] HR_SPLIT = 2'b11;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_ADDR,
    S_DATA,
    S_BACKOFF
  } mst_state_e;

endpackage

// File: rtl/ahbm_rb_backoff.sv
module ahbm_rb_backoff #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             step,
  input  logic             tick,
  input  logic [DLY_W-1:0] cfg_base,
  input  logic [DLY_W-1:0] cfg_max,
  output logic             expired
);

  logic [DLY_W-1:0] cur_q;
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] start_dly;
  logic [DLY_W-1:0] next_dly;
  logic [DLY_W:0]   dbl;

  always_comb begin
    start_dly = (cfg_base > cfg_max) ? cfg_max : cfg_base;
    dbl       = {cur_q, 1'b0};
    next_dly  = (dbl > {1'b0, cfg_max}) ? cfg_max : dbl[DLY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
      cnt_q <= '0;
    end else begin
      if (init) begin
        cur_q <= start_dly;
      end else if (step) begin
        cur_q <= next_dly;
      end
      if (step) begin
        cnt_q <= cur_q;
      end else if (tick && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign expired = (cnt_q == '0);

  // R7: a loaded wait never exceeds the ceiling
  a_r7_load_capped: assert property (@(posedge clk) disable iff (rst)
    step |=> cnt_q <= cfg_max);

  // R6: a running wait shrinks by exactly one each cycle
  a_r6_counts_down: assert property (@(posedge clk) disable iff (rst)
    (tick && !expired && !step) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/ahbm_rb_tries.sv
module ahbm_rb_tries #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             bump,
  input  logic [CNT_W-1:0] limit,
  output logic             exhausted
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (bump) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign exhausted = (cnt_q == limit);

  // R8: the sequencer never asks for a reissue past the limit
  a_r8_no_bump_past_limit: assert property (@(posedge clk) disable iff (rst)
    bump |-> !exhausted);

  // R11: a new command starts counting from zero
  a_r11_clear_to_zero: assert property (@(posedge clk) disable iff (rst)
    clear |=> cnt_q == '0);

endmodule

// File: rtl/ahbm_retry_backoff.sv
module ahbm_retry_backoff
  import ahbm_rb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DLY_W  = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DLY_W-1:0]  cfg_base_dly,
  input  logic [DLY_W-1:0]  cfg_max_dly,
  input  logic [CNT_W-1:0]  cfg_retry_limit,
  input  logic              cmd_req,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_done,
  output logic              cmd_fail,
  output logic [DATA_W-1:0] cmd_rdata,
  output logic              hbusreq,
  input  logic              hgrant,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [DATA_W-1:0] hwdata,
  input  logic [DATA_W-1:0] hrdata,
  input  logic              hready,
  input  logic [1:0]        hresp
);

  localparam logic [2:0] SIZE_CODE = 3'($clog2(DATA_W / 8));

  mst_state_e state_q, state_n;

  logic              cmd_start;
  logic              t_bump, t_step, t_tick;
  logic              fin_ok, fin_bad;
  logic              expired, exhausted;
  logic              rsp_retry;

  logic              hbusreq_q, wr_q, done_q, fail_q;
  logic [1:0]        htrans_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  ahbm_rb_backoff #(.DLY_W(DLY_W)) u_backoff (
    .clk      (clk),
    .rst      (rst),
    .init     (cmd_start),
    .step     (t_step),
    .tick     (t_tick),
    .cfg_base (cfg_base_dly),
    .cfg_max  (cfg_max_dly),
    .expired  (expired)
  );

  ahbm_rb_tries #(.CNT_W(CNT_W)) u_tries (
    .clk       (clk),
    .rst       (rst),
    .clear     (cmd_start),
    .bump      (t_bump),
    .limit     (cfg_retry_limit),
    .exhausted (exhausted)
  );

  assign rsp_retry = (hresp == HR_RETRY) || (hresp == HR_SPLIT);

  always_comb begin
    state_n   = state_q;
    cmd_start = 1'b0;
    t_bump    = 1'b0;
    t_step    = 1'b0;
    t_tick    = 1'b0;
    fin_ok    = 1'b0;
    fin_bad   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (cmd_req) begin
          cmd_start = 1'b1;
          state_n   = S_REQ;
        end
      end
      S_REQ: begin
        if (hgrant && hready) state_n = S_ADDR;
      end
      S_ADDR: begin
        if (hready) state_n = S_DATA;
      end
      S_DATA: begin
        if (hready) begin
          if (hresp == HR_OKAY) begin
            fin_ok  = 1'b1;
            state_n = S_IDLE;
          end else if (!rsp_retry || exhausted) begin
            fin_bad = 1'b1;
            state_n = S_IDLE;
          end else begin
            t_bump  = 1'b1;
            t_step  = 1'b1;
            state_n = S_BACKOFF;
          end
        end
      end
      S_BACKOFF: begin
        t_tick = 1'b1;
        if (expired) state_n = S_REQ;
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      hbusreq_q <= 1'b0;
      htrans_q  <= HT_IDLE;
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
      rdata_q   <= '0;
      addr_q    <= '0;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
    end else begin
      state_q   <= state_n;
      hbusreq_q <= (state_n == S_REQ) || (state_n == S_ADDR);
      htrans_q  <= (state_n == S_ADDR) ? HT_NONSEQ : HT_IDLE;
      done_q    <= fin_ok;
      fail_q    <= fin_bad;
      if (fin_ok && !wr_q) rdata_q <= hrdata;
      if (cmd_start) begin
        addr_q  <= cmd_addr;
        wr_q    <= cmd_write;
        wdata_q <= cmd_wdata;
      end
    end
  end

  assign cmd_done  = done_q;
  assign cmd_fail  = fail_q;
  assign cmd_rdata = rdata_q;
  assign hbusreq   = hbusreq_q;
  assign htrans    = htrans_q;
  assign haddr     = addr_q;
  assign hwrite    = wr_q;
  assign hsize     = SIZE_CODE;
  assign hwdata    = wdata_q;

  // R2: an address phase stalled by the slave keeps its address and type
  a_r2_addr_held: assert property (@(posedge clk) disable iff (rst)
    (htrans == HT_NONSEQ && !hready) |=>
      (htrans == HT_NONSEQ && $stable(haddr) && $stable(hwrite)));

  // R3: completion is a single-cycle pulse
  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> !cmd_done);

  // R5: nothing is pipelined behind a transfer that is being retried
  a_r5_cancel_next: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DATA && !hready && rsp_retry) |=> htrans == HT_IDLE);

  // R6: the bus is left alone during the backoff wait
  a_r6_silent_backoff: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_BACKOFF) |-> (!hbusreq && htrans == HT_IDLE));

  // R9: an error response ends the command without a retry
  a_r9_error_ends: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DATA && hready && hresp == HR_ERROR) |=>
      (cmd_fail && state_q == S_IDLE));

  // R9: never done and failed together
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cmd_done && cmd_fail));

  // R10: the captured transfer is frozen while a command runs
  a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_IDLE) |=> ($stable(haddr) && $stable(hwdata) && $stable(hwrite)));

endmodule

// File: tb/test_ahbm_retry_backoff.sv
`timescale 1ns/1ps
module test_ahbm_retry_backoff;

  localparam int AW = 16, DW = 32, DLY_W = 6, CNT_W = 3;
  localparam logic [1:0] T_IDLE = 2'b00, T_NSEQ = 2'b10;
  localparam logic [1:0] R_OKAY = 2'b00, R_ERR = 2'b01, R_RETRY = 2'b10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [DLY_W-1:0] cfg_base_dly = '0, cfg_max_dly = '0;
  logic [CNT_W-1:0] cfg_retry_limit = '0;
  logic             cmd_req = 1'b0, cmd_write = 1'b0;
  logic [AW-1:0]    cmd_addr = '0;
  logic [DW-1:0]    cmd_wdata = '0;
  logic             cmd_done, cmd_fail, hbusreq, hwrite;
  logic [DW-1:0]    cmd_rdata, hwdata;
  logic [AW-1:0]    haddr;
  logic [1:0]       htrans;
  logic [2:0]       hsize;
  logic             hgrant = 1'b0, hready = 1'b1;
  logic [1:0]       hresp = R_OKAY;
  logic [DW-1:0]    hrdata = '0;

  ahbm_retry_backoff #(.ADDR_W(AW), .DATA_W(DW), .DLY_W(DLY_W), .CNT_W(CNT_W)) i_ahbm_retry_backoff (
    .clk(clk), .rst(rst),
    .cfg_base_dly(cfg_base_dly), .cfg_max_dly(cfg_max_dly), .cfg_retry_limit(cfg_retry_limit),
    .cmd_req(cmd_req), .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_wdata(cmd_wdata),
    .cmd_done(cmd_done), .cmd_fail(cmd_fail), .cmd_rdata(cmd_rdata),
    .hbusreq(hbusreq), .hgrant(hgrant), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hsize(hsize), .hwdata(hwdata), .hrdata(hrdata), .hready(hready), .hresp(hresp)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scripted command and mirrored configuration
  int            cb, cm, cl;
  int            pl_retries;
  bit            pl_err, pl_write;
  logic [AW-1:0] pl_addr;
  logic [DW-1:0] pl_wdata, pl_rdata;

  // slave model state
  int            attempts, retry_seen, gap, wleft, sph;
  bit            gap_on, exp_done_nxt, exp_fail_nxt, prev_nseq, prev_rdy, prev_write;
  logic [AW-1:0] prev_addr;
  string         fail_tag;

  function automatic int exp_delay(int idx);
    int d = (cb > cm) ? cm : cb;
    for (int k = 0; k < idx; k++) begin
      d = d * 2;
      if (d > cm) d = cm;
    end
    return d;
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      hready = 1'b1; hresp = R_OKAY; hgrant = 1'b0; sph = 0;
      prev_nseq = 1'b0; prev_rdy = 1'b1; gap_on = 1'b0;
      exp_done_nxt = 1'b0; exp_fail_nxt = 1'b0;
    end else begin
      if (exp_done_nxt) begin
        chk("R3", "done one cycle after OKAY", cmd_done, 1);
        if (!pl_write) chk("R3", "read data", cmd_rdata, pl_rdata);
        exp_done_nxt = 1'b0;
      end
      if (exp_fail_nxt) begin
        chk(fail_tag, "fail one cycle after final response", cmd_fail, 1);
        chk("R9", "no done with fail", cmd_done, 0);
        exp_fail_nxt = 1'b0;
      end
      if (gap_on) begin
        if (!hbusreq) begin
          gap++;
          chk("R6", "htrans idle during backoff", htrans, T_IDLE);
        end else begin
          chk("R7", "backoff gap length", gap, exp_delay(retry_seen - 1) + 1);
          gap_on = 1'b0;
        end
      end
      if (sph == 2) begin
        chk("R5", "htrans idle in second retry cycle", htrans, T_IDLE);
        hready = 1'b1;
        sph = 0;
        if (hresp == R_RETRY) begin
          retry_seen++;
          if (retry_seen <= cl) begin
            gap_on = 1'b1; gap = 0;
          end else begin
            exp_fail_nxt = 1'b1; fail_tag = "R8";
          end
        end else begin
          exp_fail_nxt = 1'b1; fail_tag = "R9";
        end
      end else if ((prev_nseq && prev_rdy) || sph == 1) begin
        if (prev_nseq && prev_rdy) begin
          attempts++;
          chk("R4", "address on attempt", prev_addr, pl_addr);
          chk("R4", "direction on attempt", prev_write, pl_write);
          wleft = $urandom % 3;
          sph = 1;
        end
        if (wleft > 0) begin
          hready = 1'b0; hresp = R_OKAY; wleft--;
        end else begin
          if (pl_write) chk("R4", "write data on attempt", hwdata, pl_wdata);
          if (attempts - 1 < pl_retries) hresp = R_RETRY;
          else if (pl_err)               hresp = R_ERR;
          else                           hresp = R_OKAY;
          if (hresp == R_OKAY) begin
            hready = 1'b1; hrdata = pl_rdata; sph = 0; exp_done_nxt = 1'b1;
          end else begin
            hready = 1'b0; sph = 2;
          end
        end
      end else begin
        hready = 1'b1; hresp = R_OKAY;
      end
      hgrant     = hbusreq && ($urandom % 4 != 0);
      prev_nseq  = (htrans == T_NSEQ);
      prev_rdy   = hready;
      prev_addr  = haddr;
      prev_write = hwrite;
    end
  end

  task automatic set_cfg(int b, int m, int l);
    @(negedge clk);
    cfg_base_dly = DLY_W'(b); cfg_max_dly = DLY_W'(m); cfg_retry_limit = CNT_W'(l);
    cb = b; cm = m; cl = l;
  endtask

  task automatic run_cmd(logic [AW-1:0] a, bit w, logic [DW-1:0] wd, logic [DW-1:0] rd,
                         int retries, bit err, bit junk);
    int  n_done = 0, n_fail = 0, cyc = 0, exp_att;
    bit  injected = 1'b0, exp_fail;
    pl_addr = a; pl_write = w; pl_wdata = wd; pl_rdata = rd;
    pl_retries = retries; pl_err = err;
    attempts = 0; retry_seen = 0;
    @(negedge clk);
    cmd_addr = a; cmd_write = w; cmd_wdata = wd; cmd_req = 1'b1;
    @(negedge clk);
    cmd_req = 1'b0; cmd_addr = ~a; cmd_wdata = ~wd; cmd_write = ~w;
    forever begin
      @(negedge clk);
      cyc++;
      if (cmd_done) n_done++;
      if (cmd_fail) n_fail++;
      if (junk && !injected && gap_on) begin
        cmd_req = 1'b1; injected = 1'b1;   // R10 stray request mid-command
      end else begin
        cmd_req = 1'b0;
      end
      if (n_done + n_fail > 0) break;
      if (cyc > 4000) begin
        chk("R3", "command finished", 0, 1);
        break;
      end
    end
    cmd_req  = 1'b0;
    exp_fail = err || (retries > cl);
    exp_att  = ((retries < cl) ? retries : cl) + 1;
    chk("R3", "done count", n_done, exp_fail ? 0 : 1);
    chk(retries > cl ? "R8" : "R9", "fail count", n_fail, exp_fail ? 1 : 0);
    chk("R8", "attempt count", attempts, exp_att);
    repeat (3) begin
      @(negedge clk);
      chk("R1", "no request after command", hbusreq, 0);
      chk("R1", "no pulse after command", cmd_done | cmd_fail, 0);
    end
    if (junk) chk("R10", "stray request started nothing", attempts, exp_att);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1", "reset hbusreq", hbusreq, 0);
    chk("R1", "reset htrans", htrans, T_IDLE);
    chk("R1", "reset done/fail", cmd_done | cmd_fail, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "idle htrans", htrans, T_IDLE);
    chk("R2", "hsize word", hsize, 2);

    set_cfg(2, 12, 3);
    run_cmd(16'h1234, 1'b0, 32'h0, 32'hCAFE_0001, 0, 1'b0, 1'b0);   // R2 R3 plain read
    run_cmd(16'h0040, 1'b1, 32'hA5A5_5A5A, 32'h0, 2, 1'b0, 1'b1);   // R4 write reissued
    run_cmd(16'h0080, 1'b0, 32'h0, 32'h0, 4, 1'b0, 1'b0);           // R8 exhaust, R7 gaps 3,5,9
    run_cmd(16'h0084, 1'b0, 32'h0, 32'hBEEF_0002, 1, 1'b0, 1'b0);   // R11 fresh start
    set_cfg(3, 10, 5);
    run_cmd(16'h0100, 1'b0, 32'h0, 32'h1111_2222, 5, 1'b0, 1'b1);   // R7 cap reached
    run_cmd(16'h0104, 1'b1, 32'h7, 32'h0, 0, 1'b1, 1'b0);           // R9 error first
    run_cmd(16'h0108, 1'b0, 32'h0, 32'h0, 1, 1'b1, 1'b0);           // R9 error after retry
    set_cfg(4, 9, 0);
    run_cmd(16'h0200, 1'b0, 32'h0, 32'h0, 1, 1'b0, 1'b0);           // R8 limit zero
    set_cfg(20, 7, 2);
    run_cmd(16'h0300, 1'b1, 32'hDEAD_BEEF, 32'h0, 2, 1'b0, 1'b0);   // R7 base above max
    set_cfg(0, 5, 3);
    run_cmd(16'h0304, 1'b0, 32'h0, 32'h5555_AAAA, 3, 1'b0, 1'b0);   // R6 zero delay

    for (int i = 0; i < 40; i++) begin
      if (i % 5 == 0) set_cfg($urandom % 8, $urandom % 64, $urandom % 8);
      run_cmd(AW'($urandom), 1'($urandom), $urandom, $urandom,
              $urandom % (cl + 2), ($urandom % 5) == 0, ($urandom % 3) == 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule